// File: doc/BRIEF.md
# Flash Erase/Program Timing Sequencer

This block runs the timed command sequences of an embedded NOR flash macro. A write to the control word starts one operation: mass erase, page erase, program (plain or auto), reference-cell erase or trim recall. The sequencer raises `busy` and steps the macro through timed phases, driving one phase strobe at a time. The length of each phase is a cycle count taken from three packed timing words. When the last phase ends, `busy` falls and `op_done` pulses for one cycle.

The register decode and the analog macro are outside the block. The timing words and the address word arrive as plain inputs, and the macro sees only the phase strobes, the operation code and the page index. The block snapshots the timing fields and the page index when a command starts, so nothing written during an operation can disturb it.

States and transitions of the state machine:
- `ST_IDLE`: waits for a command.
- `ST_SETUP`: setup phase. It goes to `ST_RECALL` for a trim recall and to `ST_ACTIVE` for every other operation.
- `ST_ACTIVE`: the erase or program pulse, followed by `ST_HOLD`.
- `ST_HOLD`: the non-volatile hold, followed by `ST_DONE`.
- `ST_RECALL`: the short recall phase, followed by `ST_DONE`.
- `ST_DONE`: lasts one cycle. It returns to `ST_IDLE`, or goes to `ST_SETUP` if a new command arrives in that cycle.

Top module: `flash_op_sequencer`

## Requirements
- R1: After reset, `busy`, `op_done`, `macro_sleep` and all four phase strobes are low, and `op_sel` is 0 (none).
- R2: A control write accepted while not busy decodes its bits as follows: bit 3 is mass erase (`op_sel`=1), bit 4 is page erase (2), bit 5 or bit 8 is program (3), bit 6 is reference-cell erase (4) and bit 7 is trim recall (5). When several of these bits are set, the lowest-numbered one wins.
- R3: Mass, page and reference-cell erase run three phases in order. Setup asserts `ph_setup` for timing2[27:24] cycles. Active asserts `ph_active` for timing1[23:0] cycles. Hold asserts `ph_hold` for timing0[31:16] cycles.
- R4: Program uses the same phases as R3, but its active phase lasts timing2[15:0] cycles.
- R5: Trim recall runs setup for timing2[27:24] cycles, then asserts `ph_recall` for timing2[23:16] cycles. It never asserts `ph_active` or `ph_hold`.
- R6: A count field of zero gives a phase of exactly one cycle.
- R7: `busy` rises in the cycle after the accepted write and stays high through the last phase. In the following cycle `busy` is low and `op_done` is high for exactly one cycle.
- R8: A control write while `busy` is high is ignored, sleep bit included: the running operation, its phase lengths and `macro_sleep` are unchanged.
- R9: `page_idx` is the address input shifted right by 12 (4096-byte pages), captured when a command starts and held while busy.
- R10: Timing inputs are sampled when a command starts. Changing them during an operation does not alter that operation.
- R11: Bit 0 of an accepted control write sets `macro_sleep`. A write with no operation bits set updates sleep without raising `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_we | input | 1 | Control write strobe |
| cmd_wdata | input | 9 | Control write data |
| timing0 | input | 32 | Hold count [31:16], read wait states [5:0] |
| timing1 | input | 32 | Erase count [23:0] |
| timing2 | input | 32 | Setup count [27:24], recall count [23:16], program count [15:0] |
| addr | input | 32 | Erase/program address |
| busy | output | 1 | Operation in progress |
| op_done | output | 1 | One-cycle completion pulse |
| op_sel | output | 3 | Operation code of the current/last operation |
| ph_setup | output | 1 | Setup phase strobe |
| ph_active | output | 1 | Erase/program pulse strobe |
| ph_hold | output | 1 | Non-volatile hold strobe |
| ph_recall | output | 1 | Trim recall strobe |
| page_idx | output | 20 | Captured page number |
| macro_sleep | output | 1 | Sleep select to the macro |

## Verification
A control write driven before clock edge e takes effect at e. `busy`, `op_sel`, `page_idx` and `ph_setup` are therefore due at the first falling edge after e. From that point each phase strobe stays high for exactly its programmed count of cycles, and `op_done` is high on the falling edge that follows the last phase cycle. The bench drives every input and samples every output on falling edges. It counts the falling edges on which each strobe is high and compares the counts with the fields it programmed. Writes made mid-operation are placed at a chosen busy cycle, so their effect can be checked against the same expected counts.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

    localparam int CTRL_W     = 9;
    localparam int CB_SLEEP   = 0;
    localparam int CB_MASS    = 3;
    localparam int CB_PAGE    = 4;
    localparam int CB_PROG    = 5;
    localparam int CB_REFC    = 6;
    localparam int CB_RECALL  = 7;
    localparam int CB_AUTO    = 8;

    localparam int NVH_W   = 16;
    localparam int ERASE_W = 24;
    localparam int PROG_W  = 16;
    localparam int H100_W  = 8;
    localparam int T10_W   = 4;

    typedef enum logic [2:0] {
        OP_NONE   = 3'd0,
        OP_MASS   = 3'd1,
        OP_PAGE   = 3'd2,
        OP_PROG   = 3'd3,
        OP_REFC   = 3'd4,
        OP_RECALL = 3'd5
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_ACTIVE,
        ST_HOLD,
        ST_RECALL,
        ST_DONE
    } state_e;

    typedef struct packed {
        logic [NVH_W-1:0]   nvh;
        logic [ERASE_W-1:0] erase;
        logic [PROG_W-1:0]  prog;
        logic [H100_W-1:0]  h100;
        logic [T10_W-1:0]   t10;
    } timing_t;

endpackage

// File: rtl/flash_cmd_decode.sv
module flash_cmd_decode
    import flash_seq_pkg::*;
(
    input  logic [CTRL_W-1:0] wdata,
    output op_e               op
);
    // lowest-numbered command bit wins
    always_comb begin
        if (wdata[CB_MASS])
            op = OP_MASS;
        else if (wdata[CB_PAGE])
            op = OP_PAGE;
        else if (wdata[CB_PROG] || wdata[CB_AUTO])
            op = OP_PROG;
        else if (wdata[CB_REFC])
            op = OP_REFC;
        else if (wdata[CB_RECALL])
            op = OP_RECALL;
        else
            op = OP_NONE;
    end
endmodule

// File: rtl/flash_timing_unpack.sv
module flash_timing_unpack
    import flash_seq_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic [WORD_W-1:0] t0_word,
    input  logic [WORD_W-1:0] t1_word,
    input  logic [WORD_W-1:0] t2_word,
    output timing_t           fields
);
    localparam int NVH_LSB  = 16;
    localparam int H100_LSB = 16;
    localparam int T10_LSB  = 24;

    always_comb begin
        fields.nvh   = t0_word[NVH_LSB +: NVH_W];
        fields.erase = t1_word[0 +: ERASE_W];
        fields.prog  = t2_word[0 +: PROG_W];
        fields.h100  = t2_word[H100_LSB +: H100_W];
        fields.t10   = t2_word[T10_LSB +: T10_W];
    end
endmodule

// File: rtl/flash_phase_timer.sv
module flash_phase_timer #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] len,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    // a length of zero behaves as one cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= (len == '0) ? '0 : len - 1'b1;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/flash_op_sequencer.sv
module flash_op_sequencer
    import flash_seq_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int WORD_W     = 32,
    parameter int PAGE_SHIFT = 12,
    localparam int PAGE_W    = ADDR_W - PAGE_SHIFT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_we,
    input  logic [CTRL_W-1:0] cmd_wdata,
    input  logic [WORD_W-1:0] timing0,
    input  logic [WORD_W-1:0] timing1,
    input  logic [WORD_W-1:0] timing2,
    input  logic [ADDR_W-1:0] addr,
    output logic              busy,
    output logic              op_done,
    output logic [2:0]        op_sel,
    output logic              ph_setup,
    output logic              ph_active,
    output logic              ph_hold,
    output logic              ph_recall,
    output logic [PAGE_W-1:0] page_idx,
    output logic              macro_sleep
);
    localparam int CNT_W = ERASE_W;

    state_e            state_q, state_n;
    op_e               dec_op, op_q;
    timing_t           tim_in, tim_q;
    logic [PAGE_W-1:0] page_q;
    logic              sleep_q;
    logic              can_accept, start;
    logic              tmr_load, tmr_exp;
    logic [CNT_W-1:0]  tmr_len;

    flash_cmd_decode u_dec (
        .wdata (cmd_wdata),
        .op    (dec_op)
    );

    flash_timing_unpack #(.WORD_W(WORD_W)) u_unpack (
        .t0_word (timing0),
        .t1_word (timing1),
        .t2_word (timing2),
        .fields  (tim_in)
    );

    assign can_accept = cmd_we && ((state_q == ST_IDLE) || (state_q == ST_DONE));
    assign start      = can_accept && (dec_op != OP_NONE);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_n;
    end

    // command snapshot
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q    <= OP_NONE;
            tim_q   <= '0;
            page_q  <= '0;
            sleep_q <= 1'b0;
        end else begin
            if (can_accept)
                sleep_q <= cmd_wdata[CB_SLEEP];
            if (start) begin
                op_q   <= dec_op;
                tim_q  <= tim_in;
                page_q <= addr[PAGE_SHIFT +: PAGE_W];
            end
        end
    end

    // next state
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_n = ST_SETUP;
            ST_SETUP:  if (tmr_exp) state_n = (op_q == OP_RECALL) ? ST_RECALL : ST_ACTIVE;
            ST_ACTIVE: if (tmr_exp) state_n = ST_HOLD;
            ST_HOLD:   if (tmr_exp) state_n = ST_DONE;
            ST_RECALL: if (tmr_exp) state_n = ST_DONE;
            ST_DONE:   state_n = start ? ST_SETUP : ST_IDLE;
            default:   state_n = ST_IDLE;
        endcase
    end

    // phase length for the state being entered; timing comes from the
    // snapshot, or straight from the inputs on the start cycle
    always_comb begin
        tmr_len = '0;
        unique case (state_n)
            ST_SETUP:  tmr_len = CNT_W'(start ? tim_in.t10 : tim_q.t10);
            ST_ACTIVE: tmr_len = (op_q == OP_PROG) ? CNT_W'(tim_q.prog) : tim_q.erase;
            ST_HOLD:   tmr_len = CNT_W'(tim_q.nvh);
            ST_RECALL: tmr_len = CNT_W'(tim_q.h100);
            ST_IDLE, ST_DONE: tmr_len = '0;
            default:   tmr_len = '0;
        endcase
    end

    assign tmr_load = (state_n != state_q);

    flash_phase_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .len     (tmr_len),
        .expired (tmr_exp)
    );

    // outputs
    always_comb begin
        busy      = 1'b0;
        op_done   = 1'b0;
        ph_setup  = 1'b0;
        ph_active = 1'b0;
        ph_hold   = 1'b0;
        ph_recall = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_SETUP:  begin busy = 1'b1; ph_setup  = 1'b1; end
            ST_ACTIVE: begin busy = 1'b1; ph_active = 1'b1; end
            ST_HOLD:   begin busy = 1'b1; ph_hold   = 1'b1; end
            ST_RECALL: begin busy = 1'b1; ph_recall = 1'b1; end
            ST_DONE:   op_done = 1'b1;
            default:   ;
        endcase
    end

    assign op_sel      = op_q;
    assign page_idx    = page_q;
    assign macro_sleep = sleep_q;

endmodule

// File: rtl/flash_op_sequencer_chk.sv
module flash_op_sequencer_chk #(
    parameter int PAGE_W = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_we,
    input logic              busy,
    input logic              op_done,
    input logic [2:0]        op_sel,
    input logic              ph_setup,
    input logic              ph_active,
    input logic              ph_hold,
    input logic              ph_recall,
    input logic [PAGE_W-1:0] page_idx,
    input logic              macro_sleep
);
    p_one_phase_r3: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> ($countones({ph_setup, ph_active, ph_hold, ph_recall}) == 1));

    p_recall_path_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 3'd5) |-> (!ph_active && !ph_hold));

    p_done_after_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        op_done |-> (!busy && $past(busy)));

    p_busy_needs_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(cmd_we));

    p_ignore_op_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_we) |=> $stable(op_sel));

    p_ignore_sleep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_we) |=> $stable(macro_sleep));

    p_page_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(page_idx));
endmodule

bind flash_op_sequencer flash_op_sequencer_chk #(.PAGE_W(PAGE_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_we      (cmd_we),
    .busy        (busy),
    .op_done     (op_done),
    .op_sel      (op_sel),
    .ph_setup    (ph_setup),
    .ph_active   (ph_active),
    .ph_hold     (ph_hold),
    .ph_recall   (ph_recall),
    .page_idx    (page_idx),
    .macro_sleep (macro_sleep)
);

// File: tb/flash_op_sequencer_tb.sv
module flash_op_sequencer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_we = 1'b0;
    logic [8:0]  cmd_wdata = '0;
    logic [31:0] timing0 = '0, timing1 = '0, timing2 = '0, addr = '0;
    logic        busy, op_done, ph_setup, ph_active, ph_hold, ph_recall, macro_sleep;
    logic [2:0]  op_sel;
    logic [19:0] page_idx;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    always #10 clk = ~clk;  // 50 MHz

    flash_op_sequencer u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
        .timing0(timing0), .timing1(timing1), .timing2(timing2), .addr(addr),
        .busy(busy), .op_done(op_done), .op_sel(op_sel),
        .ph_setup(ph_setup), .ph_active(ph_active), .ph_hold(ph_hold),
        .ph_recall(ph_recall), .page_idx(page_idx), .macro_sleep(macro_sleep)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected<=100000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic set_timing(input int t10, input int h100, input int prog,
                              input int erase, input int nvh);
        timing0 = {nvh[15:0], 10'd0, 6'd2};
        timing1 = {8'd0, erase[23:0]};
        timing2 = {4'd0, t10[3:0], h100[7:0], prog[15:0]};
    endtask

    // issue a command and measure each phase length; optionally inject a
    // control write and a new timing2 word at busy cycle inj_at
    task automatic run_op(input string req, input logic [8:0] cmd, input int exp_op,
                          input int es, input int ea, input int eh, input int er,
                          input int inj_at, input logic [8:0] inj_cmd,
                          input logic [31:0] inj_t2);
        int ns = 0, na = 0, nh = 0, nr = 0, total = 0;
        @(negedge clk);
        cmd_we = 1'b1;
        cmd_wdata = cmd;
        @(negedge clk);
        cmd_we = 1'b0;
        chk(busy == 1'b1, req, "busy after write", busy, 1);
        chk(op_sel == exp_op[2:0], req, "op_sel", op_sel, exp_op);
        while (busy && total < 5000) begin
            if (ph_setup) ns++;
            if (ph_active) na++;
            if (ph_hold) nh++;
            if (ph_recall) nr++;
            if (total == inj_at) begin
                cmd_we = 1'b1;
                cmd_wdata = inj_cmd;
                timing2 = inj_t2;
            end else begin
                cmd_we = 1'b0;
            end
            total++;
            @(negedge clk);
        end
        cmd_we = 1'b0;
        chk(ns == es, req, "setup cycles", ns, es);
        chk(na == ea, req, "active cycles", na, ea);
        chk(nh == eh, req, "hold cycles", nh, eh);
        chk(nr == er, req, "recall cycles", nr, er);
        chk(op_sel == exp_op[2:0], req, "op_sel at end", op_sel, exp_op);
        chk(op_done == 1'b1 && busy == 1'b0, "R7", "op_done pulse", op_done, 1);
        @(negedge clk);
        chk(op_done == 1'b0, "R7", "op_done width", op_done, 0);
    endtask

    task automatic t_reset;
        chk(busy == 0 && op_done == 0, "R1", "busy/done", {busy, op_done}, 0);
        chk({ph_setup, ph_active, ph_hold, ph_recall} == 0, "R1", "strobes",
            {ph_setup, ph_active, ph_hold, ph_recall}, 0);
        chk(op_sel == 0 && macro_sleep == 0, "R1", "op/sleep", {op_sel, macro_sleep}, 0);
    endtask

    task automatic t_erase_ops;  // R3
        set_timing(3, 5, 7, 10, 4);
        run_op("R3", 9'h008, 1, 3, 10, 4, 0, -1, 9'h0, timing2);
        addr = 32'h0000_5A34;
        run_op("R3", 9'h010, 2, 3, 10, 4, 0, -1, 9'h0, timing2);
        chk(page_idx == 20'd5, "R9", "page_idx", page_idx, 5);
        run_op("R3", 9'h040, 4, 3, 10, 4, 0, -1, 9'h0, timing2);
    endtask

    task automatic t_program;  // R4
        set_timing(3, 5, 7, 10, 4);
        run_op("R4", 9'h020, 3, 3, 7, 4, 0, -1, 9'h0, timing2);
        run_op("R4", 9'h100, 3, 3, 7, 4, 0, -1, 9'h0, timing2);
    endtask

    task automatic t_recall;  // R5
        set_timing(3, 5, 7, 10, 4);
        run_op("R5", 9'h080, 5, 3, 0, 0, 5, -1, 9'h0, timing2);
    endtask

    task automatic t_priority;  // R2
        set_timing(2, 2, 2, 2, 2);
        run_op("R2", 9'h028, 1, 2, 2, 2, 0, -1, 9'h0, timing2);
        run_op("R2", 9'h0C0, 4, 2, 2, 2, 0, -1, 9'h0, timing2);
        run_op("R2", 9'h130, 2, 2, 2, 2, 0, -1, 9'h0, timing2);
    endtask

    task automatic t_zero;  // R6
        set_timing(0, 0, 0, 0, 0);
        run_op("R6", 9'h008, 1, 1, 1, 1, 0, -1, 9'h0, timing2);
        run_op("R6", 9'h080, 5, 1, 0, 0, 1, -1, 9'h0, timing2);
    endtask

    task automatic t_ignore;  // R8
        set_timing(3, 5, 7, 10, 4);
        addr = 32'h0001_2000;
        run_op("R8", 9'h010, 2, 3, 10, 4, 0, 4, 9'h081, timing2);
        chk(macro_sleep == 1'b0, "R8", "sleep unchanged", macro_sleep, 0);
        chk(page_idx == 20'h12, "R9", "page_idx", page_idx, 18);
    endtask

    task automatic t_snapshot;  // R10
        logic [31:0] t2_new;
        set_timing(3, 5, 7, 10, 4);
        t2_new = {4'd0, 4'd9, 8'd9, 16'd20};
        run_op("R10", 9'h020, 3, 3, 7, 4, 0, 1, 9'h000, t2_new);
    endtask

    task automatic t_sleep;  // R11
        @(negedge clk);
        cmd_we = 1'b1;
        cmd_wdata = 9'h001;
        @(negedge clk);
        cmd_we = 1'b0;
        chk(macro_sleep == 1'b1, "R11", "sleep set", macro_sleep, 1);
        chk(busy == 1'b0, "R11", "no busy", busy, 0);
        @(negedge clk);
        cmd_we = 1'b1;
        cmd_wdata = 9'h000;
        @(negedge clk);
        cmd_we = 1'b0;
        chk(macro_sleep == 1'b0, "R11", "sleep cleared", macro_sleep, 0);
        set_timing(1, 1, 1, 1, 1);
        run_op("R11", 9'h009, 1, 1, 1, 1, 0, -1, 9'h0, timing2);
        chk(macro_sleep == 1'b1, "R11", "sleep with op", macro_sleep, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_erase_ops();
        t_program();
        t_recall();
        t_priority();
        t_zero();
        t_ignore();
        t_snapshot();
        t_sleep();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule